// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Aggregator

The block gathers a vector of level-sensitive interrupt sources and reduces it to two processor interrupt levels: a normal request (`irqOut`) and a fast request (`fiqOut`). Both paths see the same source vector. A small bank of timer request lines is ORed into a run of consecutive source bit positions before either path sees them. Each path has its own enable mask. Software never writes a mask as a whole. It sets bits through one register and clears bits through another.

Software uses a simple single-cycle register bus: a 3-bit address, a write strobe and write data. Read data is always the view selected by the current address. Bit 2 of the address picks the path (0 = normal, 1 = fast). Bits 1:0 pick the view: 0 = raw sources, 1 = masked sources, 2 = mask set, 3 = mask clear. Both outputs are registered. A write to a status view changes nothing and raises a sticky error flag that only reset clears.

Top module: `irq_fiq_merge`

## Requirements
- R1: Reading view 0 (raw) of either path returns the combined source vector, with no mask applied.
- R2: Reading view 1 (masked) of a path returns the combined source vector ANDed with that path's mask.
- R3: A write to view 2 (set) of a path ORs `wrData` into that path's mask at the next clock edge.
- R4: A write to view 3 (clear) of a path clears, at the next clock edge, every mask bit written as one and keeps the others.
- R5: Reading view 2 or view 3 of a path returns that path's current mask.
- R6: At each clock edge `irqOut` takes the OR-reduction of (combined sources AND normal mask), using the values present just before that edge.
- R7: `fiqOut` is formed in the same way from the fast mask. A mask write to one path never alters the other path's mask.
- R8: Timer line k (`tmrIn[k]`) is ORed into combined source bit TMR_BASE+k. The default TMR_BASE is 4, so the timers occupy bits 7:4.
- R9: A write to view 0 or view 1 of either path leaves both masks unchanged and sets `busErr`. Once set, `busErr` stays high until reset.
- R10: While reset is asserted and right after it, both masks are zero and `irqOut`, `fiqOut` and `busErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Level-sensitive source lines |
| tmrIn | input | NUM_TMR | Timer request lines merged at TMR_BASE |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register select: bit 2 picks the path, bits 1:0 pick the view |
| wrData | input | NUM_SRC | Register write data |
| rdData | output | NUM_SRC | Data of the currently addressed view |
| irqOut | output | 1 | Normal interrupt level, registered |
| fiqOut | output | 1 | Fast interrupt level, registered |
| busErr | output | 1 | Sticky flag for writes to a status view |

## Verification
The bench goes after the case where a write sets or clears a mask bit whose source is already active. A design that combined the new mask into the output in the same cycle, or lagged by two cycles, would show an output edge one cycle early or late. Timer lines are driven while the matching source lines are low. An off-by-one in the merge position would show the timer bit in the wrong place in the raw view, or drive the output from the wrong mask bit. Writes to status views are mixed with mask writes to check two things: that such a write does not corrupt a mask, and that the error flag does not drop again. A long run of random writes to both paths would catch any leak from one path's mask into the other's.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Number of interrupt outputs: path 0 is the normal request, path 1 the fast one.
  localparam int NUM_PATH = 2;
  localparam int ADDR_W   = 3;

  // View codes carried in addr[1:0].
  localparam logic [1:0] VIEW_RAW = 2'd0;
  localparam logic [1:0] VIEW_MSK = 2'd1;
  localparam logic [1:0] VIEW_SET = 2'd2;
  localparam logic [1:0] VIEW_CLR = 2'd3;

  // Strobes sent from the control decode to the datapath.
  typedef struct packed {
    logic [NUM_PATH-1:0] setStb;
    logic [NUM_PATH-1:0] clrStb;
    logic                errStb;
  } strobe_t;

endpackage

// File: rtl/irqagg_dp.sv
module irqagg_dp
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_TMR  = 4,
  parameter int TMR_BASE = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  strobe_t                            stb,
  input  logic [NUM_SRC-1:0]                 wrData,
  input  logic [NUM_SRC-1:0]                 srcIn,
  input  logic [NUM_TMR-1:0]                 tmrIn,
  output logic [NUM_SRC-1:0]                 srcAll,
  output logic [NUM_PATH-1:0][NUM_SRC-1:0]   maskArr,
  output logic                               irqOut,
  output logic                               fiqOut,
  output logic                               busErr
);

  localparam int TMR_TOP = TMR_BASE + NUM_TMR;

  logic [NUM_PATH-1:0] outReg;

  // Merge the timer lines into their source positions.
  for (genvar b = 0; b < NUM_SRC; b++) begin : gMerge
    if (b >= TMR_BASE && b < TMR_TOP) begin : gTmr
      assign srcAll[b] = srcIn[b] | tmrIn[b-TMR_BASE];
    end else begin : gPlain
      assign srcAll[b] = srcIn[b];
    end
  end

  // One mask and one registered output per path.
  for (genvar p = 0; p < NUM_PATH; p++) begin : gPath
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskArr[p] <= '0;
      end else if (stb.setStb[p]) begin
        maskArr[p] <= maskArr[p] | wrData;
      end else if (stb.clrStb[p]) begin
        maskArr[p] <= maskArr[p] & ~wrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outReg[p] <= 1'b0;
      end else begin
        outReg[p] <= |(srcAll & maskArr[p]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busErr <= 1'b0;
    end else if (stb.errStb) begin
      busErr <= 1'b1;
    end
  end

  assign irqOut = outReg[0];
  assign fiqOut = outReg[1];

endmodule

// File: rtl/irqagg_ctl.sv
module irqagg_ctl
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                              wrEn,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [NUM_SRC-1:0]                srcAll,
  input  logic [NUM_PATH-1:0][NUM_SRC-1:0]  maskArr,
  output strobe_t                           stb,
  output logic [NUM_SRC-1:0]                rdData
);

  logic               pathSel;
  logic [1:0]         viewSel;
  logic [NUM_SRC-1:0] selMask;

  assign pathSel = addr[2];
  assign viewSel = addr[1:0];
  assign selMask = maskArr[pathSel];

  // Write decode into strobes.
  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (viewSel)
        VIEW_SET: stb.setStb[pathSel] = 1'b1;
        VIEW_CLR: stb.clrStb[pathSel] = 1'b1;
        default:  stb.errStb          = 1'b1;
      endcase
    end
  end

  // Read view selection.
  always_comb begin
    unique case (viewSel)
      VIEW_RAW: rdData = srcAll;
      VIEW_MSK: rdData = srcAll & selMask;
      default:  rdData = selMask;
    endcase
  end

endmodule

// File: rtl/irq_fiq_merge.sv
module irq_fiq_merge
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_TMR  = 4,
  parameter int TMR_BASE = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_TMR-1:0] tmrIn,
  input  logic               wrEn,
  input  logic [2:0]         addr,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut,
  output logic               fiqOut,
  output logic               busErr
);

  strobe_t                            stb;
  logic [NUM_SRC-1:0]                 srcAll;
  logic [NUM_PATH-1:0][NUM_SRC-1:0]   maskArr;

  irqagg_ctl #(.NUM_SRC(NUM_SRC)) uCtl (
    .wrEn    (wrEn),
    .addr    (addr),
    .srcAll  (srcAll),
    .maskArr (maskArr),
    .stb     (stb),
    .rdData  (rdData)
  );

  irqagg_dp #(
    .NUM_SRC  (NUM_SRC),
    .NUM_TMR  (NUM_TMR),
    .TMR_BASE (TMR_BASE)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .srcIn   (srcIn),
    .tmrIn   (tmrIn),
    .srcAll  (srcAll),
    .maskArr (maskArr),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut),
    .busErr  (busErr)
  );

endmodule

// File: rtl/irq_fiq_merge_chk.sv
module irq_fiq_merge_chk #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_TMR  = 4,
  parameter int TMR_BASE = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIn,
  input logic [NUM_TMR-1:0] tmrIn,
  input logic               wrEn,
  input logic [2:0]         addr,
  input logic [NUM_SRC-1:0] wrData,
  input logic               irqOut,
  input logic               fiqOut,
  input logic               busErr,
  input logic [NUM_SRC-1:0] maskIrq,
  input logic [NUM_SRC-1:0] maskFiq
);

  logic [NUM_SRC-1:0] tmrWide;
  logic [NUM_SRC-1:0] srcMix;
  assign tmrWide = NUM_SRC'(tmrIn);
  assign srcMix  = srcIn | (tmrWide << TMR_BASE);

  AST_SET_ORS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'b010) |=> ((maskIrq & $past(wrData)) == $past(wrData)) &&
                                 ((maskIrq & $past(maskIrq)) == $past(maskIrq))); // R3

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'b111) |=> ((maskFiq & $past(wrData)) == '0)); // R4

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == |($past(srcMix) & $past(maskIrq)))); // R6

  AST_FIQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (fiqOut == |($past(srcMix) & $past(maskFiq)))); // R7

  AST_PATH_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[2] == 1'b0) |=> $stable(maskFiq)); // R7

  AST_STATUS_WR_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr[1] == 1'b0) |=> busErr && $stable(maskIrq) && $stable(maskFiq)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> busErr); // R9

endmodule

bind irq_fiq_merge irq_fiq_merge_chk #(
  .NUM_SRC  (NUM_SRC),
  .NUM_TMR  (NUM_TMR),
  .TMR_BASE (TMR_BASE)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .srcIn   (srcIn),
  .tmrIn   (tmrIn),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .irqOut  (irqOut),
  .fiqOut  (fiqOut),
  .busErr  (busErr),
  .maskIrq (maskArr[0]),
  .maskFiq (maskArr[1])
);

// File: tb/sim_irq_fiq_merge.sv
module sim_irq_fiq_merge;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [3:0]  tmrIn = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut, fiqOut, busErr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference state.
  logic [31:0] mI = '0, mF = '0;
  logic        eIrq = 1'b0, eFiq = 1'b0, eErr = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  irq_fiq_merge u0 (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .tmrIn(tmrIn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut),
    .fiqOut(fiqOut), .busErr(busErr)
  );

  function automatic logic [31:0] combined();
    logic [31:0] v;
    v = srcIn;
    for (int k = 0; k < 4; k++) if (tmrIn[k]) v[4+k] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] expRead();
    logic [31:0] m;
    m = addr[2] ? mF : mI;
    case (addr[1:0])
      2'd0:    return combined();
      2'd1:    return combined() & m;
      default: return m;
    endcase
  endfunction

  // Behavioural model, advanced on each clock edge.
  always @(posedge clk) begin
    if (!rstN) begin
      mI <= '0; mF <= '0; eIrq <= 1'b0; eFiq <= 1'b0; eErr <= 1'b0;
    end else begin
      eIrq <= (combined() & mI) != 0;
      eFiq <= (combined() & mF) != 0;
      if (wrEn) begin
        if (addr[1] == 1'b0) eErr <= 1'b1;
        else if (addr[2] == 1'b0) mI <= addr[0] ? (mI & ~wrData) : (mI | wrData);
        else                      mF <= addr[0] ? (mF & ~wrData) : (mF | wrData);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison mid-cycle.
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R6 irqOut", {31'd0, irqOut}, {31'd0, eIrq});
      check("R7 fiqOut", {31'd0, fiqOut}, {31'd0, eFiq});
      check("R9 busErr", {31'd0, busErr}, {31'd0, eErr});
      case (addr[1:0])
        2'd0:    check("R1 raw view", rdData, expRead());
        2'd1:    check("R2 masked view", rdData, expRead());
        default: check("R5 mask view", rdData, expRead());
      endcase
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, string tag, logic [31:0] exp);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    check(tag, rdData, exp);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R10: reset state during reset.
    addr = 3'b010;
    @(negedge clk);
    check("R10 irq mask in reset", rdData, 32'h0);
    check("R10 outputs in reset", {29'd0, irqOut, fiqOut, busErr}, 32'h0);
    #1 rstN = 1'b1;
    peek(3'b110, "R10 fiq mask after reset", 32'h0);

    // R3: set ORs bits in.
    wr(3'b010, 32'h0000_00F0);
    wr(3'b010, 32'h8000_0001);
    peek(3'b010, "R3 set accumulates", 32'h8000_00F1);
    peek(3'b011, "R5 clear view reads mask", 32'h8000_00F1);

    // R8: timer line 2 lands on bit 6.
    @(posedge clk); #1;
    srcIn = '0; tmrIn = 4'b0100; addr = 3'b000;
    @(negedge clk);
    check("R8 timer merge position", rdData, 32'h0000_0040);
    @(negedge clk);
    check("R8 timer drives irqOut", {31'd0, irqOut}, 32'd1);
    @(posedge clk); #1 tmrIn = '0;

    // R4: clear selected bits only.
    wr(3'b011, 32'h0000_0030);
    peek(3'b010, "R4 clear drops ones only", 32'h8000_00C1);

    // R7: fast path independent.
    wr(3'b110, 32'h0000_0100);
    peek(3'b010, "R7 irq mask untouched", 32'h8000_00C1);
    @(posedge clk); #1 srcIn = 32'h0000_0100; addr = 3'b101;
    @(negedge clk);
    check("R2 fiq masked view", rdData, 32'h0000_0100);
    @(negedge clk);
    check("R7 fiqOut rises", {30'd0, fiqOut, irqOut}, 32'd2);

    // R9: status writes are inert and flag an error.
    wr(3'b001, 32'hFFFF_FFFF);
    wr(3'b100, 32'hFFFF_FFFF);
    peek(3'b110, "R9 fiq mask unchanged", 32'h0000_0100);
    peek(3'b010, "R9 irq mask unchanged", 32'h8000_00C1);
    check("R9 error flag set", {31'd0, busErr}, 32'd1);

    // Random traffic against the model.
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      srcIn  = $urandom();
      tmrIn  = 4'($urandom());
      addr   = 3'($urandom());
      wrData = $urandom();
      wrEn   = ($urandom() % 3) == 0 && addr[1];
    end
    @(posedge clk); #1 wrEn = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule